// File: doc/BRIEF.md
# Display Pixel Output Formatter

This block is the last pixel stage before a panel interface. It accepts one or two RGB pixels per clock together with vertical sync, horizontal sync and data enable. It puts each pixel through a per-component transform: optional red/blue exchange, optional bit-order reversal, then a right shift of 0 to 4 bits. It then steers the results onto two output channels, A and B. In single-wide mode one pixel per clock goes to one selected channel. In double-wide mode a left and a right pixel go to A and B, in either order.

To limit switching on the panel link, the block can invert a channel word whenever more than half of its bits would otherwise toggle against the previous word on that channel. It raises a per-channel flag for every word it inverts. In double-wide mode the decision can be taken jointly over both channels or separately for each. The sync and enable outputs have selectable polarity and a gate. The data outputs have a gate of their own. A clock-polarity level is passed on to the output driver.

All controls sit in one 16-bit configuration register that is written through a write strobe. Every output is registered, so each result follows its inputs by one clock.

Top module: `pixel_out_formatter`

## Requirements
- R1: The configuration register is written from `cfgWord` at a rising edge on which `cfgWe` is 1. It clears to 0 on reset. After reset every output is 0, because both output gates start closed. Bit map: 0 double-wide, 1 channel select, 2 red/blue exchange, 3 bit reversal, 6:4 shift code, 7 separate inversion, 8 inversion enable, 9 flag polarity, 10 clock invert, 11 enable polarity, 12 horizontal polarity, 13 vertical polarity, 14 sync gate open, 15 data gate open.
- R2: Every output is registered. Pixels and syncs presented in one cycle appear after the next rising edge. A configuration write affects the pixels presented in the cycle after the write.
- R3: In single-wide mode (bit 0 = 0), `pixLeft` drives channel A when bit 1 is 0 and channel B when bit 1 is 1. The other channel and its flag stay 0.
- R4: In double-wide mode (bit 0 = 1), bit 1 = 0 puts `pixLeft` on A and `pixRight` on B. Bit 1 = 1 swaps that mapping.
- R5: Pixels are packed red in [23:16], green in [15:8] and blue in [7:0]. With bit 2 set, the red and blue components exchange places.
- R6: With bit 3 set, each 8-bit component is bit-reversed: its bit 7 moves to bit 0, and so on. This is applied after the exchange of R5.
- R7: Shift codes 0 to 4 shift each component right by that many bits, after R6, filling with zeros. Codes 5 to 7 apply no shift.
- R8: Each sync output equals its input XOR its polarity bit (bit 13 vertical, bit 12 horizontal, bit 11 enable). The output `clkInvOut` repeats bit 10.
- R9: With inversion enabled (bit 8) and per-channel decisions, an active channel word is inverted when more than 12 of its 24 bits differ from that channel's previous output word. The channel flag then equals decision XOR bit 9. Per-channel decisions apply in single-wide mode, or when bit 7 is set.
- R10: In double-wide mode with bit 7 = 0, both channels are inverted together when more than 24 of the 48 bits differ from the previous outputs. Both flags are then equal.
- R11: With bit 8 clear, no word is inverted and both flags are 0.
- R12: With bit 15 clear, both channel words and both flags are 0.
- R13: With bit 14 clear, the vertical sync, horizontal sync and enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 16 | Configuration value written on strobe |
| pixLeft | input | 24 | Single-wide pixel or left pixel |
| pixRight | input | 24 | Right pixel in double-wide mode |
| vsyncIn | input | 1 | Vertical sync in |
| hsyncIn | input | 1 | Horizontal sync in |
| deIn | input | 1 | Data enable in |
| chA | output | 24 | Channel A word |
| chB | output | 24 | Channel B word |
| invFlagA | output | 1 | Channel A inversion flag |
| invFlagB | output | 1 | Channel B inversion flag |
| vsyncOut | output | 1 | Vertical sync out |
| hsyncOut | output | 1 | Horizontal sync out |
| deOut | output | 1 | Data enable out |
| clkInvOut | output | 1 | Output clock polarity level |

## Verification
Every channel word, flag and sync output is due one rising edge after its inputs are presented. A configuration write first governs the pixels presented in the following cycle. The bench drives each cycle's inputs at a falling edge and compares the outputs at the next falling edge. Its model applies a written configuration only after computing that cycle's expected values, so it follows the same one-cycle offset. The inversion reference in the model is its own expected previous word for each channel, never a value read back from the design.

// File: rtl/pof_pkg.sv
package pof_pkg;

  localparam int CFG_W = 16;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic       dataEn;
    logic       tconEn;
    logic       vsPol;
    logic       hsPol;
    logic       dePol;
    logic       clkInv;
    logic       flagPol;
    logic       invEn;
    logic       invSeparate;
    logic [2:0] shiftAmt;
    logic       bitFlip;
    logic       swapRB;
    logic       chanSel;
    logic       dualWide;
  } ctrl_t;

endpackage

// File: rtl/pof_ctrl.sv
module pof_ctrl
  import pof_pkg::*;
#(
  parameter int MAX_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  output ctrl_t            ctrlStrb
);

  logic [CFG_W-1:0] cfgReg;
  logic [2:0]       rawShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWord;
  end

  assign rawShift = cfgReg[6:4];

  always_comb begin
    ctrlStrb.dualWide    = cfgReg[0];
    ctrlStrb.chanSel     = cfgReg[1];
    ctrlStrb.swapRB      = cfgReg[2];
    ctrlStrb.bitFlip     = cfgReg[3];
    // reserved codes fall back to no shift
    ctrlStrb.shiftAmt    = (rawShift > 3'(MAX_SHIFT)) ? 3'd0 : rawShift;
    ctrlStrb.invSeparate = cfgReg[7];
    ctrlStrb.invEn       = cfgReg[8];
    ctrlStrb.flagPol     = cfgReg[9];
    ctrlStrb.clkInv      = cfgReg[10];
    ctrlStrb.dePol       = cfgReg[11];
    ctrlStrb.hsPol       = cfgReg[12];
    ctrlStrb.vsPol       = cfgReg[13];
    ctrlStrb.tconEn      = cfgReg[14];
    ctrlStrb.dataEn      = cfgReg[15];
  end

endmodule

// File: rtl/pof_datapath.sv
module pof_datapath
  import pof_pkg::*;
#(
  parameter int COMP_W   = 8,
  parameter int NUM_COMP = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrlStrb,
  input  logic [COMP_W*NUM_COMP-1:0]   pixLeft,
  input  logic [COMP_W*NUM_COMP-1:0]   pixRight,
  input  logic                         vsyncIn,
  input  logic                         hsyncIn,
  input  logic                         deIn,
  output logic [COMP_W*NUM_COMP-1:0]   chA,
  output logic [COMP_W*NUM_COMP-1:0]   chB,
  output logic                         invFlagA,
  output logic                         invFlagB,
  output logic                         vsyncOut,
  output logic                         hsyncOut,
  output logic                         deOut,
  output logic                         clkInvOut
);

  localparam int PIX_W = COMP_W * NUM_COMP;
  localparam int CNT_W = $clog2(2 * PIX_W + 1);

  logic [1:0][PIX_W-1:0] srcPix;
  logic [1:0][PIX_W-1:0] fmtPix;

  assign srcPix = {pixRight, pixLeft};

  // Per-lane, per-component transform: exchange, reverse, shift
  for (genvar l = 0; l < 2; l++) begin : g_lane
    for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
      localparam int SWAP_K = (k == 0) ? NUM_COMP - 1 :
                              ((k == NUM_COMP - 1) ? 0 : k);
      logic [COMP_W-1:0] picked;
      logic [COMP_W-1:0] flipped;
      always_comb begin
        picked = ctrlStrb.swapRB ? srcPix[l][SWAP_K*COMP_W +: COMP_W]
                                 : srcPix[l][k*COMP_W +: COMP_W];
        for (int b = 0; b < COMP_W; b++) begin
          flipped[b] = ctrlStrb.bitFlip ? picked[COMP_W-1-b] : picked[b];
        end
      end
      assign fmtPix[l][k*COMP_W +: COMP_W] = flipped >> ctrlStrb.shiftAmt;
    end
  end

  logic [PIX_W-1:0] candA, candB, nextA, nextB;
  logic [CNT_W-1:0] togA, togB;
  logic             actA, actB, jointMode, decA, decB;

  always_comb begin
    actA = ctrlStrb.dualWide | ~ctrlStrb.chanSel;
    actB = ctrlStrb.dualWide |  ctrlStrb.chanSel;
    if (ctrlStrb.dualWide) begin
      candA = ctrlStrb.chanSel ? fmtPix[1] : fmtPix[0];
      candB = ctrlStrb.chanSel ? fmtPix[0] : fmtPix[1];
    end else begin
      candA = ctrlStrb.chanSel ? '0 : fmtPix[0];
      candB = ctrlStrb.chanSel ? fmtPix[0] : '0;
    end
    togA      = CNT_W'($countones(candA ^ chA));
    togB      = CNT_W'($countones(candB ^ chB));
    jointMode = ctrlStrb.dualWide & ~ctrlStrb.invSeparate;
    if (jointMode) begin
      decA = (togA + togB) > CNT_W'(PIX_W);
      decB = decA;
    end else begin
      decA = actA && (togA > CNT_W'(PIX_W / 2));
      decB = actB && (togB > CNT_W'(PIX_W / 2));
    end
    decA  = decA & ctrlStrb.invEn;
    decB  = decB & ctrlStrb.invEn;
    nextA = decA ? ~candA : candA;
    nextB = decB ? ~candB : candB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chA       <= '0;
      chB       <= '0;
      invFlagA  <= 1'b0;
      invFlagB  <= 1'b0;
      vsyncOut  <= 1'b0;
      hsyncOut  <= 1'b0;
      deOut     <= 1'b0;
      clkInvOut <= 1'b0;
    end else begin
      chA       <= ctrlStrb.dataEn ? nextA : '0;
      chB       <= ctrlStrb.dataEn ? nextB : '0;
      invFlagA  <= ctrlStrb.dataEn & ctrlStrb.invEn & actA & (decA ^ ctrlStrb.flagPol);
      invFlagB  <= ctrlStrb.dataEn & ctrlStrb.invEn & actB & (decB ^ ctrlStrb.flagPol);
      vsyncOut  <= (vsyncIn ^ ctrlStrb.vsPol) & ctrlStrb.tconEn;
      hsyncOut  <= (hsyncIn ^ ctrlStrb.hsPol) & ctrlStrb.tconEn;
      deOut     <= (deIn ^ ctrlStrb.dePol) & ctrlStrb.tconEn;
      clkInvOut <= ctrlStrb.clkInv;
    end
  end

endmodule

// File: rtl/pixel_out_formatter.sv
module pixel_out_formatter
  import pof_pkg::*;
#(
  parameter int COMP_W    = 8,
  parameter int NUM_COMP  = 3,
  parameter int MAX_SHIFT = 4,
  parameter int PIX_W     = COMP_W * NUM_COMP
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic [PIX_W-1:0] pixLeft,
  input  logic [PIX_W-1:0] pixRight,
  input  logic             vsyncIn,
  input  logic             hsyncIn,
  input  logic             deIn,
  output logic [PIX_W-1:0] chA,
  output logic [PIX_W-1:0] chB,
  output logic             invFlagA,
  output logic             invFlagB,
  output logic             vsyncOut,
  output logic             hsyncOut,
  output logic             deOut,
  output logic             clkInvOut
);

  ctrl_t ctrlStrb;

  pof_ctrl #(.MAX_SHIFT(MAX_SHIFT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWord  (cfgWord),
    .ctrlStrb (ctrlStrb)
  );

  pof_datapath #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlStrb  (ctrlStrb),
    .pixLeft   (pixLeft),
    .pixRight  (pixRight),
    .vsyncIn   (vsyncIn),
    .hsyncIn   (hsyncIn),
    .deIn      (deIn),
    .chA       (chA),
    .chB       (chB),
    .invFlagA  (invFlagA),
    .invFlagB  (invFlagB),
    .vsyncOut  (vsyncOut),
    .hsyncOut  (hsyncOut),
    .deOut     (deOut),
    .clkInvOut (clkInvOut)
  );

endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataEn,
  input logic             tconEn,
  input logic             dualWide,
  input logic             chanSel,
  input logic             invEn,
  input logic             invSeparate,
  input logic             clkInv,
  input logic             vsPol,
  input logic             hsPol,
  input logic             dePol,
  input logic             vsyncIn,
  input logic             hsyncIn,
  input logic             deIn,
  input logic [PIX_W-1:0] chA,
  input logic [PIX_W-1:0] chB,
  input logic             invFlagA,
  input logic             invFlagB,
  input logic             vsyncOut,
  input logic             hsyncOut,
  input logic             deOut,
  input logic             clkInvOut
);

  assert_data_blank_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |=> (chA == '0 && chB == '0 && !invFlagA && !invFlagB));

  assert_tcon_blank_R13: assert property (@(posedge clk) disable iff (!rstN)
    !tconEn |=> (!vsyncOut && !hsyncOut && !deOut));

  // R2 latency and R8 polarity of the timing outputs
  assert_sync_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    tconEn |=> (vsyncOut == ($past(vsyncIn) ^ $past(vsPol)) &&
                hsyncOut == ($past(hsyncIn) ^ $past(hsPol)) &&
                deOut    == ($past(deIn)    ^ $past(dePol))));

  assert_clk_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    clkInv |=> clkInvOut);

  assert_single_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && !dualWide && !chanSel) |=> (chB == '0 && !invFlagB));

  assert_toggle_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && invEn && !dualWide && !chanSel) |=>
      ($countones(chA ^ $past(chA)) <= PIX_W / 2));

  assert_joint_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataEn && invEn && dualWide && !invSeparate) |=> (invFlagA == invFlagB));

  assert_no_invert_R11: assert property (@(posedge clk) disable iff (!rstN)
    !invEn |=> (!invFlagA && !invFlagB));

endmodule

bind pixel_out_formatter pof_checker #(.PIX_W(PIX_W)) u_pofChecker (
  .clk         (clk),
  .rstN        (rstN),
  .dataEn      (ctrlStrb.dataEn),
  .tconEn      (ctrlStrb.tconEn),
  .dualWide    (ctrlStrb.dualWide),
  .chanSel     (ctrlStrb.chanSel),
  .invEn       (ctrlStrb.invEn),
  .invSeparate (ctrlStrb.invSeparate),
  .clkInv      (ctrlStrb.clkInv),
  .vsPol       (ctrlStrb.vsPol),
  .hsPol       (ctrlStrb.hsPol),
  .dePol       (ctrlStrb.dePol),
  .vsyncIn     (vsyncIn),
  .hsyncIn     (hsyncIn),
  .deIn        (deIn),
  .chA         (chA),
  .chB         (chB),
  .invFlagA    (invFlagA),
  .invFlagB    (invFlagB),
  .vsyncOut    (vsyncOut),
  .hsyncOut    (hsyncOut),
  .deOut       (deOut),
  .clkInvOut   (clkInvOut)
);

// File: tb/test_pixel_out_formatter.sv
`timescale 1ns/1ps
module test_pixel_out_formatter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWord = '0;
  logic [23:0] pixLeft = '0, pixRight = '0;
  logic        vsyncIn = 1'b0, hsyncIn = 1'b0, deIn = 1'b0;
  logic [23:0] chA, chB;
  logic        invFlagA, invFlagB, vsyncOut, hsyncOut, deOut, clkInvOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mCfg = '0;
  logic [23:0] prevA = '0, prevB = '0;

  localparam logic [15:0] EN = 16'hC000;

  always #2.5 clk = ~clk;

  pixel_out_formatter i_pixel_out_formatter (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .pixLeft(pixLeft), .pixRight(pixRight),
    .vsyncIn(vsyncIn), .hsyncIn(hsyncIn), .deIn(deIn),
    .chA(chA), .chB(chB), .invFlagA(invFlagA), .invFlagB(invFlagB),
    .vsyncOut(vsyncOut), .hsyncOut(hsyncOut), .deOut(deOut),
    .clkInvOut(clkInvOut)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] fmtPix(input logic [23:0] p, input logic [15:0] c);
    logic [7:0] comp [3];
    logic [7:0] t;
    logic [23:0] r;
    int sh;
    comp[0] = p[7:0]; comp[1] = p[15:8]; comp[2] = p[23:16];
    if (c[2]) begin t = comp[0]; comp[0] = comp[2]; comp[2] = t; end
    sh = int'(c[6:4]);
    if (sh > 4) sh = 0;
    for (int k = 0; k < 3; k++) begin
      t = comp[k];
      if (c[3]) for (int b = 0; b < 8; b++) t[b] = comp[k][7-b];
      t = t >> sh;
      r[k*8 +: 8] = t;
    end
    return r;
  endfunction

  // One cycle: compute expected with current model config, drive, check.
  task automatic doCycle(input bit we, input logic [15:0] word,
                         input logic [23:0] p0, input logic [23:0] p1,
                         input bit vs, input bit hs, input bit de,
                         input string tag);
    logic [23:0] fa, fb, ca, cb, eA, eB;
    int ta, tb;
    bit dual, sel, actA, actB, ia, ib, fA, fB, dEn, iEn;
    bit eVs, eHs, eDe, eClk;
    dual = mCfg[0]; sel = mCfg[1]; dEn = mCfg[15]; iEn = mCfg[8];
    fa = fmtPix(p0, mCfg); fb = fmtPix(p1, mCfg);
    if (dual) begin ca = sel ? fb : fa; cb = sel ? fa : fb; end
    else begin ca = sel ? 24'h0 : fa; cb = sel ? fa : 24'h0; end
    actA = dual || !sel; actB = dual || sel;
    ta = $countones(ca ^ prevA); tb = $countones(cb ^ prevB);
    if (dual && !mCfg[7]) begin ia = (ta + tb) > 24; ib = ia; end
    else begin ia = actA && ta > 12; ib = actB && tb > 12; end
    ia = ia && iEn; ib = ib && iEn;
    eA = dEn ? (ia ? ~ca : ca) : 24'h0;
    eB = dEn ? (ib ? ~cb : cb) : 24'h0;
    fA = dEn && iEn && actA && (ia ^ mCfg[9]);
    fB = dEn && iEn && actB && (ib ^ mCfg[9]);
    eVs = (vs ^ mCfg[13]) & mCfg[14];
    eHs = (hs ^ mCfg[12]) & mCfg[14];
    eDe = (de ^ mCfg[11]) & mCfg[14];
    eClk = mCfg[10];
    prevA = eA; prevB = eB;
    if (we) mCfg = word;
    cfgWe = we; cfgWord = word; pixLeft = p0; pixRight = p1;
    vsyncIn = vs; hsyncIn = hs; deIn = de;
    @(negedge clk);
    cfgWe = 1'b0;
    chk(tag, "data", {14'd0, chA, chB, invFlagA, invFlagB},
                     {14'd0, eA, eB, fA, fB});
    chk(tag, "sync", {60'd0, vsyncOut, hsyncOut, deOut, clkInvOut},
                     {60'd0, eVs, eHs, eDe, eClk});
  endtask

  task automatic wr(input logic [15:0] w, input string tag);
    doCycle(1'b1, w, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic px(input logic [23:0] p0, input logic [23:0] p1, input string tag);
    doCycle(1'b0, 16'h0, p0, p1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {chA, chB, invFlagA, invFlagB, vsyncOut, hsyncOut, deOut, clkInvOut}, '0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: default configuration blanks everything; write enables
    doCycle(1'b1, EN, 24'h123456, 24'h654321, 1'b1, 1'b1, 1'b1, "R1");
    chk("R1", "blank after reset", {chA, vsyncOut}, '0);
    // R3 single-wide steering
    px(24'h123456, 24'h777777, "R3");
    chk("R3", "single A", {chA, chB}, {24'h123456, 24'h0});
    wr(EN | 16'h0002, "R3");
    px(24'hABCDEF, 24'h0, "R3");
    chk("R3", "single B", {chA, chB}, {24'h0, 24'hABCDEF});
    // R4 double-wide mapping
    wr(EN | 16'h0001, "R4");
    px(24'h111111, 24'h222222, "R4");
    chk("R4", "dual normal", {chA, chB}, {24'h111111, 24'h222222});
    wr(EN | 16'h0003, "R4");
    px(24'h111111, 24'h222222, "R4");
    chk("R4", "dual swapped", {chA, chB}, {24'h222222, 24'h111111});
    // R5 exchange
    wr(EN | 16'h0004, "R5");
    px(24'hAA55CC, 24'h0, "R5");
    chk("R5", "red blue exchange", chA, 24'hCC55AA);
    // R6 reversal
    wr(EN | 16'h0008, "R6");
    px(24'h0180F0, 24'h0, "R6");
    chk("R6", "bit reverse", chA, 24'h80010F);
    // R7 shifts including reserved codes
    for (int s = 0; s < 8; s++) begin
      wr(EN | 16'(s << 4), "R7");
      px(24'hFF8040, 24'h0, "R7");
      if (s == 2) chk("R7", "shift 2", chA, 24'h3F2010);
      if (s == 5) chk("R7", "reserved shift", chA, 24'hFF8040);
    end
    // R8 polarity and clock level
    wr(EN | 16'h3800 | 16'h0400, "R8");
    doCycle(1'b0, 16'h0, 24'h0, 24'h0, 1'b1, 1'b0, 1'b1, "R8");
    chk("R8", "polarity", {vsyncOut, hsyncOut, deOut, clkInvOut}, 4'b0101);
    // R9 separate inversion
    wr(EN | 16'h0100, "R9");
    px(24'h0, 24'h0, "R9");
    px(24'hFFFFFF, 24'h0, "R9");
    chk("R9", "invert full toggle", {chA, invFlagA}, {24'h0, 1'b1});
    px(24'h000FFF, 24'h0, "R9");
    chk("R9", "half toggle kept", {chA, invFlagA}, {24'h000FFF, 1'b0});
    wr(EN | 16'h0300, "R9");
    px(24'h000FFF, 24'h0, "R9");
    chk("R9", "flag polarity", {chA, invFlagA}, {24'h000FFF, 1'b1});
    // R10 joint inversion
    wr(EN | 16'h0101, "R10");
    px(24'h0, 24'h0, "R10");
    px(24'hFFFFFF, 24'hFFF000, "R10");
    chk("R10", "joint invert", {chA, chB, invFlagA, invFlagB}, {24'h0, 24'h000FFF, 2'b11});
    // R11 inversion disabled
    wr(EN, "R11");
    px(24'hFFFFFF, 24'h0, "R11");
    chk("R11", "no invert", {chA, invFlagA}, {24'hFFFFFF, 1'b0});
    // R12 data gate
    wr(16'h4000, "R12");
    doCycle(1'b0, 16'h0, 24'h5A5A5A, 24'h0, 1'b1, 1'b1, 1'b1, "R12");
    chk("R12", "data blanked", {chA, chB, deOut}, {48'h0, 1'b1});
    // R13 sync gate
    wr(16'h8000, "R13");
    doCycle(1'b0, 16'h0, 24'h5A5A5A, 24'h0, 1'b1, 1'b1, 1'b1, "R13");
    chk("R13", "sync blanked", {chA, vsyncOut, hsyncOut, deOut}, {24'h5A5A5A, 3'b000});
    // R2 random mix with model
    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [15:0] w;
      we = ($urandom % 16) == 0;
      w = 16'($urandom);
      if (($urandom % 8) != 0) w = w | EN;
      doCycle(we, w, 24'($urandom), 24'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), "R2");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule